// File: doc/BRIEF.md
# Poison-Carrying SECDED Word Guard

This block guards 32-bit cache data words with a single-error-correct, double-error-detect code that also covers a per-word poison marker. Each stored word is 40 bits wide: 32 data bits, one poison bit, six Hamming check bits and one overall parity bit. The encode side is combinational. It turns write data and a poison flag into the 40-bit stored word that goes into the array.

The decode side takes a word read from the array and returns the repaired data and poison flag one clock later. With them it raises three strobes: a corrected single error, a detected double error, and a request to evict and refill the line. The requester is given the repaired word directly, so no second array read is needed after a correction. The poison flag is repaired like any data bit and comes out as decoded, so a poisoned word stays poisoned. The eviction sequencing and the array itself lie outside this block.

Top module: `secded_poison_guard`

## Requirements
- R1: The encoded word has this layout. Bits [31:0] hold the data and bit 32 holds the poison flag. Protected bit k (data bit k for k<32, poison for k=32) takes the k-th integer, counting from 3 upward, that is not a power of two (3, 5, 6, 7, 9, ... 39). Bits [38:33] hold check bits c0..c5, where cj is the XOR of every protected bit whose position has bit j set. Bit 39 is chosen so that the XOR of all 40 bits is 0.
- R2: The decode output is registered with a latency of one cycle. outValid is decValid delayed by one clock. While outValid is low, or while reset is held, all strobes and outValid are 0.
- R3: A word read back exactly as it was encoded returns its data and poison unchanged, with outDataOk=1 and outSec, outDed and outRefill all 0.
- R4: A word with any one of bits [32:0] inverted returns the original data and poison, with outSec=1, outDed=0 and outDataOk=1.
- R5: A word with any one of bits [39:33] inverted returns the original data and poison, with outSec=1, outDed=0 and outDataOk=1.
- R6: A word with exactly two bits inverted gives outDed=1, outSec=0, outDataOk=0 and outRefill=0.
- R7: outRefill is 1 in exactly the cycles where outSec is 1.
- R8: A word encoded with poison=1 decodes with outPoison=1, both when it is clean and after a single-bit correction.
- R9: An odd number of inverted bits whose combined syndrome points beyond position 39 is reported as outDed=1 with outDataOk=0, not as a correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encData | input | 32 | Write data to encode |
| encPoison | input | 1 | Poison flag to encode |
| encWord | output | 40 | Encoded stored word (combinational) |
| decValid | input | 1 | decWord holds a word to decode |
| decWord | input | 40 | Stored word read from the array |
| outValid | output | 1 | Decode result valid |
| outData | output | 32 | Corrected data |
| outPoison | output | 1 | Corrected poison flag |
| outDataOk | output | 1 | Data is trustworthy (no uncorrectable error) |
| outSec | output | 1 | Single error corrected |
| outDed | output | 1 | Uncorrectable error detected |
| outRefill | output | 1 | Request eviction and refill of the line |

## Verification
The assertions check several rules on every cycle: that the encoded word has even overall parity, that the output valid trails the input valid by one clock, and that the strobes stay quiet when no result is valid. They also check that a correction always brings a refill request, and they compare every decode against the encoder's view of the same data. In that comparison a read-back with zero, one or two differing bits must give a clean pass, a repaired word or an uncorrectable flag. Only the bench's scenarios exercise the specific check-bit positions and the poison flag passing through a correction. They also cover the case of three inverted bits that alias beyond the last code position.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W  = 32;
  localparam int PROT_W  = DATA_W + 1;

  function automatic int hamBits(input int k);
    int r;
    r = 0;
    while ((1 << r) < (k + r + 1)) r++;
    return r;
  endfunction

  localparam int HAM_W   = hamBits(PROT_W);
  localparam int CODE_W  = PROT_W + HAM_W + 1;
  localparam int MAX_POS = PROT_W + HAM_W;
  localparam int CHK_LO  = PROT_W;
  localparam int PAR_BIT = CODE_W - 1;

  // Code position of protected bit idx: idx-th non-power-of-two from 3 up.
  function automatic int posOf(input int idx);
    int n;
    int res;
    n = -1;
    res = 0;
    for (int p = 3; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        n++;
        if (n == idx && res == 0) res = p;
      end
    end
    return res;
  endfunction

  function automatic logic [HAM_W-1:0] hamCheck(input logic [PROT_W-1:0] prot);
    logic [HAM_W-1:0] c;
    c = '0;
    for (int i = 0; i < PROT_W; i++) begin
      int p;
      p = posOf(i);
      for (int j = 0; j < HAM_W; j++) begin
        if (((p >> j) & 1) == 1) c[j] = c[j] ^ prot[i];
      end
    end
    return c;
  endfunction

  typedef struct packed {
    logic             flipEn;
    logic [HAM_W-1:0] flipPos;
    logic             secHit;
    logic             dedHit;
    logic             refillReq;
  } strobe_t;
endpackage

// File: rtl/secded_ctl.sv
module secded_ctl
  import secded_pkg::*;
(
  input  logic [HAM_W-1:0] syndrome,
  input  logic             parityOdd,
  output strobe_t          strobes
);
  logic synZero;
  logic synPow2;
  logic synInRange;

  assign synZero    = (syndrome == '0);
  assign synPow2    = !synZero && ((syndrome & (syndrome - 1'b1)) == '0);
  assign synInRange = (int'(syndrome) <= MAX_POS);

  always_comb begin
    strobes = '0;
    if (!parityOdd) begin
      // even overall parity with a non-zero syndrome: two bits flipped
      strobes.dedHit = !synZero;
    end else if (synZero || synPow2) begin
      // overall parity bit or one Hamming check bit flipped: data intact
      strobes.secHit = 1'b1;
    end else if (synInRange) begin
      strobes.secHit  = 1'b1;
      strobes.flipEn  = 1'b1;
      strobes.flipPos = syndrome;
    end else begin
      // odd count but syndrome names no real position: give up
      strobes.dedHit = 1'b1;
    end
    strobes.refillReq = strobes.secHit;
  end
endmodule

// File: rtl/secded_dp.sv
module secded_dp
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  input  logic              encPoison,
  output logic [CODE_W-1:0] encWord,
  input  logic              decValid,
  input  logic [CODE_W-1:0] decWord,
  output logic [HAM_W-1:0]  syndrome,
  output logic              parityOdd,
  input  strobe_t           strobes,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outPoison,
  output logic              outDataOk,
  output logic              outSec,
  output logic              outDed,
  output logic              outRefill
);
  // encode path
  logic [PROT_W-1:0] encProt;
  logic [HAM_W-1:0]  encChk;

  assign encProt = {encPoison, encData};
  assign encChk  = hamCheck(encProt);
  assign encWord = {^{encChk, encProt}, encChk, encProt};

  // decode path
  logic [PROT_W-1:0] decProt;
  logic [HAM_W-1:0]  decChk;
  logic [PROT_W-1:0] flipMask;
  logic [PROT_W-1:0] fixedProt;

  assign decProt   = decWord[PROT_W-1:0];
  assign decChk    = decWord[CHK_LO +: HAM_W];
  assign syndrome  = hamCheck(decProt) ^ decChk;
  assign parityOdd = ^decWord;

  for (genvar i = 0; i < PROT_W; i++) begin : g_flip
    localparam int P = posOf(i);
    assign flipMask[i] = strobes.flipEn && (strobes.flipPos == HAM_W'(P));
  end

  assign fixedProt = decProt ^ flipMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outPoison <= 1'b0;
      outDataOk <= 1'b0;
      outSec    <= 1'b0;
      outDed    <= 1'b0;
      outRefill <= 1'b0;
    end else begin
      outValid  <= decValid;
      outSec    <= decValid && strobes.secHit;
      outDed    <= decValid && strobes.dedHit;
      outRefill <= decValid && strobes.refillReq;
      outDataOk <= decValid && !strobes.dedHit;
      if (decValid) begin
        outData   <= fixedProt[DATA_W-1:0];
        outPoison <= fixedProt[DATA_W];
      end
    end
  end
endmodule

// File: rtl/secded_poison_guard.sv
module secded_poison_guard
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  input  logic              encPoison,
  output logic [CODE_W-1:0] encWord,
  input  logic              decValid,
  input  logic [CODE_W-1:0] decWord,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outPoison,
  output logic              outDataOk,
  output logic              outSec,
  output logic              outDed,
  output logic              outRefill
);
  logic [HAM_W-1:0] syndrome;
  logic             parityOdd;
  strobe_t          strobes;

  secded_ctl u_ctl (
    .syndrome  (syndrome),
    .parityOdd (parityOdd),
    .strobes   (strobes)
  );

  secded_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .encData   (encData),
    .encPoison (encPoison),
    .encWord   (encWord),
    .decValid  (decValid),
    .decWord   (decWord),
    .syndrome  (syndrome),
    .parityOdd (parityOdd),
    .strobes   (strobes),
    .outValid  (outValid),
    .outData   (outData),
    .outPoison (outPoison),
    .outDataOk (outDataOk),
    .outSec    (outSec),
    .outDed    (outDed),
    .outRefill (outRefill)
  );
endmodule

// File: rtl/secded_poison_guard_chk.sv
module secded_poison_guard_chk
  import secded_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] encData,
  input logic              encPoison,
  input logic [CODE_W-1:0] encWord,
  input logic              decValid,
  input logic [CODE_W-1:0] decWord,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outPoison,
  input logic              outDataOk,
  input logic              outSec,
  input logic              outDed,
  input logic              outRefill
);
  AST_ENC_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rstN) (^encWord) == 1'b0); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) decValid |=> outValid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN) !decValid |=> !outValid); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN) !outValid |-> !(outSec || outDed || outRefill || outDataOk)); // R2
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decWord == encWord) |=>
      (outDataOk && !outSec && !outDed && outData == $past(encData) && outPoison == $past(encPoison))); // R3
  AST_SINGLE_FIX: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $countones(decWord ^ encWord) == 1) |=>
      (outSec && !outDed && outDataOk && outData == $past(encData) && outPoison == $past(encPoison))); // R4
  AST_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $countones(decWord ^ encWord) == 2) |=> (outDed && !outSec && !outDataOk && !outRefill)); // R6
  AST_REFILL_ON_FIX: assert property (@(posedge clk) disable iff (!rstN) outSec |-> outRefill); // R7
  AST_REFILL_ONLY_FIX: assert property (@(posedge clk) disable iff (!rstN) outRefill |-> (outSec && outDataOk)); // R7
endmodule

bind secded_poison_guard secded_poison_guard_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .encData   (encData),
  .encPoison (encPoison),
  .encWord   (encWord),
  .decValid  (decValid),
  .decWord   (decWord),
  .outValid  (outValid),
  .outData   (outData),
  .outPoison (outPoison),
  .outDataOk (outDataOk),
  .outSec    (outSec),
  .outDed    (outDed),
  .outRefill (outRefill)
);

// File: tb/secded_poison_guard_bench.sv
`timescale 1ns/1ps
module secded_poison_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] encData = '0;
  logic        encPoison = 1'b0;
  logic [39:0] encWord;
  logic        decValid = 1'b0;
  logic [39:0] decWord = '0;
  logic        outValid;
  logic [31:0] outData;
  logic        outPoison;
  logic        outDataOk;
  logic        outSec;
  logic        outDed;
  logic        outRefill;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  secded_poison_guard u_secded_poison_guard (
    .clk(clk), .rstN(rstN), .encData(encData), .encPoison(encPoison), .encWord(encWord),
    .decValid(decValid), .decWord(decWord), .outValid(outValid), .outData(outData),
    .outPoison(outPoison), .outDataOk(outDataOk), .outSec(outSec), .outDed(outDed),
    .outRefill(outRefill)
  );

  typedef struct packed {
    logic [31:0] data;
    logic        poison;
    logic        ok;
    logic        sec;
    logic        ded;
    logic        cmpData;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  // reference model built from the R1 description: place bits by code position
  function automatic logic [39:0] refEncode(input logic [31:0] d, input logic p);
    logic [63:0] cw;
    logic [32:0] prot;
    logic [5:0]  chk;
    int k;
    cw = '0;
    prot = {p, d};
    k = 0;
    for (int pos = 1; pos <= 39; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = prot[k];
        k++;
      end
    end
    for (int j = 0; j < 6; j++) begin
      logic acc;
      acc = 1'b0;
      for (int pos = 1; pos <= 39; pos++)
        if (((pos >> j) & 1) == 1 && (pos & (pos - 1)) != 0) acc = acc ^ cw[pos];
      chk[j] = acc;
    end
    return {^{chk, prot}, chk, prot};
  endfunction

  function automatic int refIndexOfPos(input int pos);
    int k;
    k = 0;
    for (int q = 3; q < pos; q++) if ((q & (q - 1)) != 0) k++;
    return k;
  endfunction

  task automatic checkOne(input bit cond, input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sendWord(input logic [39:0] w, input logic [31:0] d, input logic p,
                          input logic ok, input logic sec, input logic ded,
                          input logic cmpData, input string tag);
    exp_t e;
    @(negedge clk);
    encData   = d;
    encPoison = p;
    decWord   = w;
    decValid  = 1'b1;
    e.data = d; e.poison = p; e.ok = ok; e.sec = sec; e.ded = ded; e.cmpData = cmpData;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic goIdle(input int n);
    @(negedge clk);
    decValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare each result
  always @(negedge clk) begin
    #1;
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checkOne(1'b0, "R2", "unexpected result", {63'd0, outValid}, 64'd0);
      end else begin
        exp_t e;
        string t;
        bit good;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        good = (outDataOk == e.ok) && (outSec == e.sec) && (outDed == e.ded) && (outRefill == e.sec);
        if (e.cmpData) good = good && (outData == e.data) && (outPoison == e.poison);
        checkOne(good, t, "ok/sec/ded/refill/poison/data",
                 {26'd0, outDataOk, outSec, outDed, outRefill, outPoison, outData},
                 {26'd0, e.ok, e.sec, e.ded, e.sec, e.poison, e.data});
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats[6];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_5A5A;
    pats[3] = 32'h1234_5678; pats[4] = 32'h8000_0001; pats[5] = 32'h0F0F_F0F0;

    repeat (4) @(negedge clk);
    #1;
    checkOne(!outValid && !outSec && !outDed && !outRefill, "R2", "reset state",
             {60'd0, outValid, outSec, outDed, outRefill}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: encoder layout against reference
    for (int i = 0; i < 12; i++) begin
      logic [31:0] d;
      logic p;
      d = (i < 6) ? pats[i] : (32'(i) * 32'h9E37_79B9);
      p = i[0];
      @(negedge clk);
      encData = d; encPoison = p;
      #1;
      checkOne(encWord == refEncode(d, p), "R1", "encoded word",
               {24'd0, encWord}, {24'd0, refEncode(d, p)});
    end

    // R3 / R8: clean words, both poison values
    for (int i = 0; i < 6; i++) begin
      sendWord(refEncode(pats[i], 1'b0), pats[i], 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
      sendWord(refEncode(pats[i], 1'b1), pats[i], 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    end
    goIdle(3);

    // R2: strobes quiet while idle
    #1;
    checkOne(!outValid && !outSec && !outDed && !outRefill && !outDataOk, "R2", "idle strobes",
             {59'd0, outValid, outSec, outDed, outRefill, outDataOk}, 64'd0);

    // R4 / R5 / R7 / R8: every single-bit error
    for (int v = 0; v < 3; v++) begin
      for (int b = 0; b < 40; b++) begin
        logic [39:0] w;
        logic p;
        p = (v == 1);
        w = refEncode(pats[v + 2], p);
        w[b] = ~w[b];
        sendWord(w, pats[v + 2], p, 1'b1, 1'b1, 1'b0, 1'b1,
                 (b < 33) ? (p ? "R8" : "R4") : (b == 32 ? "R4" : "R5"));
      end
      goIdle(1);
    end

    // R6 / R7: double errors, refill stays low
    for (int i = 0; i < 40; i++) begin
      logic [39:0] w;
      int b2;
      b2 = (i * 7 + 3) % 40;
      if (b2 == i) b2 = (i + 1) % 40;
      w = refEncode(pats[i % 6], i[0]);
      w[i]  = ~w[i];
      w[b2] = ~w[b2];
      sendWord(w, pats[i % 6], i[0], 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    end
    goIdle(2);

    // R9: three data bits at positions 3, 9, 36 give syndrome 46 with odd parity
    begin
      logic [39:0] w;
      w = refEncode(pats[3], 1'b0);
      w[refIndexOfPos(3)]  = ~w[refIndexOfPos(3)];
      w[refIndexOfPos(9)]  = ~w[refIndexOfPos(9)];
      w[refIndexOfPos(36)] = ~w[refIndexOfPos(36)];
      sendWord(w, pats[3], 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
      w = refEncode(pats[0], 1'b1);
      w[refIndexOfPos(3)]  = ~w[refIndexOfPos(3)];
      w[refIndexOfPos(9)]  = ~w[refIndexOfPos(9)];
      w[refIndexOfPos(36)] = ~w[refIndexOfPos(36)];
      sendWord(w, pats[0], 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    end
    goIdle(3);

    checkOne(expQ.size() == 0, "R2", "all results returned", 64'(expQ.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule